// File: doc/BRIEF.md
# Multicycle Processor Step Sequencer

This block is the control unit of a multicycle processor datapath. It is a Moore state machine that walks each instruction through a series of one-cycle steps, and in every step it drives the enables and multiplexer selects that the datapath needs. Every instruction shares a fetch step and a decode step. The decode step reads the 6-bit opcode and picks a class-specific path. Each class leaves the path at its own last step and returns to fetch. A branch-if-equal therefore takes three cycles, a store and a register-register operation four, and a load five.

All outputs depend on the current step alone. The datapath registers the results of each step, and the sequencer only tells it what to capture. The opcode must be held stable from fetch until the instruction returns to fetch, which is the case when it comes from the instruction register. An opcode that is not recognised returns the machine to fetch straight after decode.

Reset is asserted asynchronously through `rst_n` and released in step with the clock. While reset is in effect, no write or memory enable is driven.

Top module: `mcyc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it goes high, `step_o` is 0 and `pc_load`, `pc_load_if_eq`, `mem_rd`, `mem_wr`, `instr_load` and `rf_wr` are all 0. Fetch outputs appear after the second edge, and a low level on `rst_n` forces step 0 at once, even in the middle of an instruction.
- R2: In step 0 (fetch), the outputs are mem_rd=1, instr_load=1, mem_addr_sel=0 (program counter), alu_a_sel=0 (program counter), alu_b_sel=01 (constant 4), alu_mode=00 (add), pc_next_sel=00 (ALU result) and pc_load=1. The next step is always 1.
- R3: In step 1 (decode), the outputs are alu_a_sel=0, alu_b_sel=11 (shifted immediate) and alu_mode=00, with no enable asserted. The next step is 2 for opcode 0x23 or 0x2B, 6 for 0x00, 8 for 0x04, and 0 for any other opcode.
- R4: A load (0x23) visits steps 0,1,2,3,4 and is back at fetch 5 cycles after it started. Step 3 drives mem_rd=1 and mem_addr_sel=1 (ALU register). Step 4 drives rf_wr=1, wb_from_mem=1 and rf_dst_sel=0 (rt field).
- R5: A store (0x2B) visits steps 0,1,2,5 and takes 4 cycles. Step 2 drives alu_a_sel=1 (register A), alu_b_sel=10 (immediate) and alu_mode=00. Step 5 drives mem_wr=1 and mem_addr_sel=1.
- R6: A register-register operation (0x00) visits steps 0,1,6,7 and takes 4 cycles. Step 6 drives alu_a_sel=1, alu_b_sel=00 (register B) and alu_mode=10 (function field). Step 7 drives rf_wr=1, rf_dst_sel=1 (rd field) and wb_from_mem=0.
- R7: A branch-if-equal (0x04) visits steps 0,1,8 and takes 3 cycles. Step 8 drives alu_a_sel=1, alu_b_sel=00, alu_mode=01 (subtract), pc_load_if_eq=1, pc_next_sel=01 (ALU register) and pc_load=0.
- R8: An unrecognised opcode visits steps 0,1 and takes 2 cycles, with no write enable asserted in decode.
- R9: mem_rd and mem_wr are never 1 in the same cycle. pc_load and instr_load are 1 only in step 0. rf_wr is 1 only in step 4 or step 7.
- R10: `step_o` never leaves the range 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| opcode | input | 6 | Opcode field of the current instruction |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_if_eq | output | 1 | Program counter write when the ALU reports zero |
| mem_addr_sel | output | 1 | Memory address select: 0 program counter, 1 ALU register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| wb_from_mem | output | 1 | Register write data select: 1 memory data register, 0 ALU register |
| instr_load | output | 1 | Instruction register write enable |
| pc_next_sel | output | 2 | Next PC source: 00 ALU result, 01 ALU register |
| alu_mode | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted left 2 |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| step_o | output | 4 | Current step number |

## Verification
The control outputs are a pure function of the registered step. They are therefore valid for the whole cycle that begins at the edge where the step changes. The step moves exactly one rising edge after it is entered, and the decode branch uses the opcode present before that edge. After `rst_n` rises, the first fetch outputs appear only after the second rising edge, while a low level on `rst_n` acts at once. The bench changes the opcode and samples every output on the falling clock edge, one check per cycle. It counts the edges from one fetch to the next and compares that count with the per-class cycle count.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

  localparam int STEP_W = 4;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_REXE   = 4'd6,
    ST_RDONE  = 4'd7,
    ST_BRANCH = 4'd8
  } step_e;

  localparam logic [STEP_W-1:0] LAST_STEP = 4'd8;

  // ALU B operand select codes
  localparam logic [1:0] BSEL_REG   = 2'b00;
  localparam logic [1:0] BSEL_FOUR  = 2'b01;
  localparam logic [1:0] BSEL_IMM   = 2'b10;
  localparam logic [1:0] BSEL_IMMSH = 2'b11;

  // ALU mode codes
  localparam logic [1:0] AMODE_ADD  = 2'b00;
  localparam logic [1:0] AMODE_SUB  = 2'b01;
  localparam logic [1:0] AMODE_FUNC = 2'b10;

  // Next PC source codes
  localparam logic [1:0] PSRC_ALU   = 2'b00;
  localparam logic [1:0] PSRC_AREG  = 2'b01;

  typedef struct packed {
    logic       pc_load;
    logic       pc_load_if_eq;
    logic       mem_addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_from_mem;
    logic       instr_load;
    logic [1:0] pc_next_sel;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_sel;
  } ctrl_t;

endpackage

// File: rtl/mcyc_rst_sync.sv
module mcyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mcyc_next_step.sv
module mcyc_next_step
  import mcyc_ctrl_pkg::*;
#(
  parameter int                OPC_W  = 6,
  parameter logic [OPC_W-1:0]  OP_REG = 6'h00,
  parameter logic [OPC_W-1:0]  OP_LD  = 6'h23,
  parameter logic [OPC_W-1:0]  OP_ST  = 6'h2B,
  parameter logic [OPC_W-1:0]  OP_BEQ = 6'h04
) (
  input  step_e            cur,
  input  logic [OPC_W-1:0] opcode,
  output step_e            nxt
);

  logic is_ld, is_st, is_reg, is_beq;

  always_comb begin
    is_ld  = (opcode == OP_LD);
    is_st  = (opcode == OP_ST);
    is_reg = (opcode == OP_REG);
    is_beq = (opcode == OP_BEQ);
  end

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (is_ld || is_st) nxt = ST_MADDR;
        else if (is_reg)    nxt = ST_REXE;
        else if (is_beq)    nxt = ST_BRANCH;
        else                nxt = ST_FETCH;
      end
      ST_MADDR: begin
        if (is_ld)      nxt = ST_LDRD;
        else if (is_st) nxt = ST_STWR;
        else            nxt = ST_FETCH;
      end
      ST_LDRD:   nxt = ST_LDWB;
      ST_LDWB:   nxt = ST_FETCH;
      ST_STWR:   nxt = ST_FETCH;
      ST_REXE:   nxt = ST_RDONE;
      ST_RDONE:  nxt = ST_FETCH;
      ST_BRANCH: nxt = ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_decode.sv
module mcyc_ctrl_decode
  import mcyc_ctrl_pkg::*;
(
  input  step_e cur,
  input  logic  run,
  output ctrl_t ctrl
);

  ctrl_t raw;

  always_comb begin
    raw = '0;
    unique case (cur)
      ST_FETCH: begin
        raw.mem_rd      = 1'b1;
        raw.instr_load  = 1'b1;
        raw.alu_b_sel   = BSEL_FOUR;
        raw.alu_mode    = AMODE_ADD;
        raw.pc_next_sel = PSRC_ALU;
        raw.pc_load     = 1'b1;
      end
      ST_DECODE: begin
        raw.alu_b_sel = BSEL_IMMSH;
        raw.alu_mode  = AMODE_ADD;
      end
      ST_MADDR: begin
        raw.alu_a_sel = 1'b1;
        raw.alu_b_sel = BSEL_IMM;
        raw.alu_mode  = AMODE_ADD;
      end
      ST_LDRD: begin
        raw.mem_rd       = 1'b1;
        raw.mem_addr_sel = 1'b1;
      end
      ST_LDWB: begin
        raw.rf_wr       = 1'b1;
        raw.wb_from_mem = 1'b1;
      end
      ST_STWR: begin
        raw.mem_wr       = 1'b1;
        raw.mem_addr_sel = 1'b1;
      end
      ST_REXE: begin
        raw.alu_a_sel = 1'b1;
        raw.alu_b_sel = BSEL_REG;
        raw.alu_mode  = AMODE_FUNC;
      end
      ST_RDONE: begin
        raw.rf_wr      = 1'b1;
        raw.rf_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        raw.alu_a_sel     = 1'b1;
        raw.alu_b_sel     = BSEL_REG;
        raw.alu_mode      = AMODE_SUB;
        raw.pc_load_if_eq = 1'b1;
        raw.pc_next_sel   = PSRC_AREG;
      end
      default: raw = '0;
    endcase
  end

  // enables are held low until reset has been released in step with the clock
  always_comb begin
    ctrl               = raw;
    ctrl.pc_load       = raw.pc_load       & run;
    ctrl.pc_load_if_eq = raw.pc_load_if_eq & run;
    ctrl.mem_rd        = raw.mem_rd        & run;
    ctrl.mem_wr        = raw.mem_wr        & run;
    ctrl.instr_load    = raw.instr_load    & run;
    ctrl.rf_wr         = raw.rf_wr         & run;
  end

endmodule

// File: rtl/mcyc_ctrl_fsm.sv
module mcyc_ctrl_fsm
  import mcyc_ctrl_pkg::*;
#(
  parameter int               OPC_W       = 6,
  parameter int               SYNC_STAGES = 2,
  parameter logic [OPC_W-1:0] OP_REG      = 6'h00,
  parameter logic [OPC_W-1:0] OP_LD       = 6'h23,
  parameter logic [OPC_W-1:0] OP_ST       = 6'h2B,
  parameter logic [OPC_W-1:0] OP_BEQ      = 6'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  output logic              pc_load,
  output logic              pc_load_if_eq,
  output logic              mem_addr_sel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              wb_from_mem,
  output logic              instr_load,
  output logic [1:0]        pc_next_sel,
  output logic [1:0]        alu_mode,
  output logic              alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic              rf_wr,
  output logic              rf_dst_sel,
  output logic [STEP_W-1:0] step_o
);

  logic  rst_int_n;
  step_e step_q;
  step_e step_d;
  ctrl_t ctrl;

  mcyc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mcyc_next_step #(
    .OPC_W (OPC_W),
    .OP_REG(OP_REG),
    .OP_LD (OP_LD),
    .OP_ST (OP_ST),
    .OP_BEQ(OP_BEQ)
  ) u_next (
    .cur   (step_q),
    .opcode(opcode),
    .nxt   (step_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) step_q <= ST_FETCH;
    else            step_q <= step_d;
  end

  mcyc_ctrl_decode u_dec (
    .cur (step_q),
    .run (rst_int_n),
    .ctrl(ctrl)
  );

  assign pc_load       = ctrl.pc_load;
  assign pc_load_if_eq = ctrl.pc_load_if_eq;
  assign mem_addr_sel  = ctrl.mem_addr_sel;
  assign mem_rd        = ctrl.mem_rd;
  assign mem_wr        = ctrl.mem_wr;
  assign wb_from_mem   = ctrl.wb_from_mem;
  assign instr_load    = ctrl.instr_load;
  assign pc_next_sel   = ctrl.pc_next_sel;
  assign alu_mode      = ctrl.alu_mode;
  assign alu_a_sel     = ctrl.alu_a_sel;
  assign alu_b_sel     = ctrl.alu_b_sel;
  assign rf_wr         = ctrl.rf_wr;
  assign rf_dst_sel    = ctrl.rf_dst_sel;
  assign step_o        = step_q;

  // ---------------- assertions ----------------
  always_comb begin
    if (rst_int_n == 1'b0) begin
      assert_quiet_in_reset_R1: assert (!pc_load && !pc_load_if_eq && !mem_rd &&
                                        !mem_wr && !instr_load && !rf_wr)
        else $error("enable active during reset");
    end
  end

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_q == ST_FETCH |=> step_q == ST_DECODE);

  assert_decode_mem_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_q == ST_DECODE && (opcode == OP_LD || opcode == OP_ST)) |=> step_q == ST_MADDR);

  assert_decode_illegal_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_q == ST_DECODE && opcode != OP_LD && opcode != OP_ST &&
     opcode != OP_REG && opcode != OP_BEQ) |=> step_q == ST_FETCH);

  assert_load_chain_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_q == ST_LDRD |=> step_q == ST_LDWB);

  assert_load_end_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_q == ST_LDWB |=> step_q == ST_FETCH);

  assert_store_end_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_q == ST_STWR |=> step_q == ST_FETCH);

  assert_reg_chain_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_q == ST_REXE |=> step_q == ST_RDONE);

  assert_branch_end_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_q == ST_BRANCH |=> step_q == ST_FETCH);

  assert_mem_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mem_rd && mem_wr));

  assert_pc_with_ir_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    pc_load |-> (instr_load && step_o == 4'd0));

  assert_rf_steps_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rf_wr |-> (step_o == 4'd4 || step_o == 4'd7));

  assert_step_range_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_o <= LAST_STEP);

endmodule

// File: tb/mcyc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module mcyc_ctrl_fsm_tb_top;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_load, pc_load_if_eq, mem_addr_sel, mem_rd, mem_wr;
  logic       wb_from_mem, instr_load, alu_a_sel, rf_wr, rf_dst_sel;
  logic [1:0] pc_next_sel, alu_mode, alu_b_sel;
  logic [3:0] step_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  mcyc_ctrl_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq), .mem_addr_sel(mem_addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
    .instr_load(instr_load), .pc_next_sel(pc_next_sel), .alu_mode(alu_mode),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr),
    .rf_dst_sel(rf_dst_sel), .step_o(step_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  typedef struct packed {
    logic [5:0] op;
    logic [3:0] cyc;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{6'h23, 4'd5}, '{6'h2B, 4'd4}, '{6'h00, 4'd4}, '{6'h04, 4'd3},
    '{6'h3F, 4'd2}, '{6'h04, 4'd3}, '{6'h23, 4'd5}, '{6'h05, 4'd2},
    '{6'h00, 4'd4}, '{6'h2B, 4'd4}
  };

  // {pc_load,pc_load_if_eq,mem_addr_sel,mem_rd,mem_wr,wb_from_mem,instr_load,
  //  pc_next_sel,alu_mode,alu_a_sel,alu_b_sel,rf_wr,rf_dst_sel}
  function automatic logic [15:0] exp_ctrl(input logic [3:0] st);
    case (st)
      4'd0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0};
      4'd1: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0};
      4'd2: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,2'b10,1'b0,1'b0};
      4'd3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
      4'd4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0};
      4'd5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
      4'd6: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,1'b1,2'b00,1'b0,1'b0};
      4'd7: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1};
      4'd8: return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,1'b1,2'b00,1'b0,1'b0};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [3:0] seq_at(input logic [5:0] op, input int k);
    if (k == 0) return 4'd0;
    if (k == 1) return 4'd1;
    case (op)
      6'h23: return (k == 2) ? 4'd2 : (k == 3) ? 4'd3 : 4'd4;
      6'h2B: return (k == 2) ? 4'd2 : 4'd5;
      6'h00: return (k == 2) ? 4'd6 : 4'd7;
      6'h04: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string class_tag(input logic [5:0] op);
    case (op)
      6'h23: return "R4";
      6'h2B: return "R5";
      6'h00: return "R6";
      6'h04: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] act_ctrl();
    return {pc_load, pc_load_if_eq, mem_addr_sel, mem_rd, mem_wr, wb_from_mem,
            instr_load, pc_next_sel, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_quiet(input string what);
    logic [5:0] en;
    en = {pc_load, pc_load_if_eq, mem_rd, mem_wr, instr_load, rf_wr};
    check(step_o == 4'd0 && en == 6'd0, "R1", what, {22'd0, step_o, en}, 32'd0);
  endtask

  // entered on a falling edge with step_o == 0
  task automatic run_instr(input logic [5:0] op, input logic [3:0] cyc);
    int    count;
    string ctag;
    string stag;
    logic [3:0] es;
    ctag  = class_tag(op);
    opcode = op;
    count = 0;
    do begin
      es = seq_at(op, count);
      stag = (es == 4'd0) ? "R2" : (es == 4'd1) ? ((ctag == "R8") ? "R8" : "R3") : ctag;
      check(step_o == es, stag, "step sequence", {28'd0, step_o}, {28'd0, es});
      check(act_ctrl() == exp_ctrl(es), stag, "control outputs",
            {16'd0, act_ctrl()}, {16'd0, exp_ctrl(es)});
      check(!(mem_rd && mem_wr) && (!pc_load || step_o == 4'd0) &&
            (!rf_wr || step_o == 4'd4 || step_o == 4'd7), "R9", "enable exclusivity",
            {28'd0, step_o}, {28'd0, es});
      check(step_o <= 4'd8, "R10", "step range", {28'd0, step_o}, 32'd8);
      count++;
      @(negedge clk);
    end while (step_o != 4'd0 && count < 8);
    check(count == int'(cyc), ctag, "cycle count", count, {28'd0, cyc});
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    opcode = 6'h00;
    repeat (3) @(negedge clk);
    check_quiet("held in reset");                         // R1
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("one edge after release");                // R1
    @(negedge clk);
    check(step_o == 4'd0 && instr_load && pc_load, "R1", "fetch after two edges",
          {30'd0, instr_load, pc_load}, 32'd3);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      run_instr(VECS[i].op, VECS[i].cyc);
    end

    // mid-instruction reset during load memory read
    opcode = 6'h23;
    repeat (3) @(negedge clk);
    check(step_o == 4'd3, "R4", "reached load read", {28'd0, step_o}, 32'd3);
    #1 rst_n = 1'b0;
    #0.5;
    check_quiet("async reset mid-load");                  // R1
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("sync window after mid reset");           // R1
    @(negedge clk);
    check(step_o == 4'd0 && mem_rd, "R1", "fetch resumes", {31'd0, mem_rd}, 32'd1);
    run_instr(6'h04, 4'd3);
    run_instr(6'h23, 4'd5);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule